// File: doc/BRIEF.md
# Pipelined Pairwise Gravity Quotient

This block computes, in fixed point, the gravitational-style quotient for a pair of point masses in a plane. The constant is set at build time as a parameter. The quotient is the constant times both masses, divided by the squared distance between the two points. Each input set carries two unsigned masses and two signed (x, y) coordinate pairs. The block returns the truncated integer quotient.

The datapath is a fixed four-stage schedule, with independent operations placed side by side in each stage:

1. The constant-times-first-mass product and both coordinate differences.
2. The second mass product and both squarings.
3. The denominator sum.
4. The divide.

A valid bit travels with each set. The block accepts a new set on every clock and never stalls. When the two points coincide, the divide is replaced by an all-ones result and an error flag rises with that result.

Top module: `grav_pipe`

## Requirements
- R1: When out_valid is high and the squared distance is nonzero, out_force equals floor(GRAV_K × m1 × m2 / ((x1 − x2)² + (y1 − y2)²)) for the set accepted four cycles earlier.
- R2: A set accepted on a rising edge with in_valid high appears with out_valid high exactly four rising edges later.
- R3: Sets presented on consecutive cycles come out on consecutive cycles, in the same order, with none lost.
- R4: When the squared distance is zero, out_force is all ones and out_div0 is 1 in the same cycle as out_valid.
- R5: out_div0 is 0 whenever out_valid is 0.
- R6: While rst_n is low, and for four cycles after its internal release, out_valid stays 0. Any sets in flight when reset is asserted are discarded.
- R7: At extreme operands there is no intermediate overflow. Extreme operands are both masses at 2^MW − 1, and coordinates at the most negative and most positive signed values.
- R8: Coordinates are two's-complement. Swapping the two points yields the same result.
- R9: Cycles with in_valid low produce cycles with out_valid low four cycles later. The gaps between sets are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operand set present this cycle |
| m1 | input | MW | First mass, unsigned |
| m2 | input | MW | Second mass, unsigned |
| x1 | input | CW | First point x, signed |
| y1 | input | CW | First point y, signed |
| x2 | input | CW | Second point x, signed |
| y2 | input | CW | Second point y, signed |
| out_valid | output | 1 | Result present this cycle |
| out_force | output | KW+2·MW | Quotient, or all ones on a zero distance |
| out_div0 | output | 1 | Zero-distance flag, qualified by out_valid |

## Verification
The bench drives coincident points, which a design without the zero guard would turn into an undefined quotient with the flag low. It drives coordinates at opposite ends of the signed range with maximum masses, where an unwidened difference or square wraps and produces a wildly wrong quotient. It swaps point order and uses negative coordinates to catch unsigned arithmetic on the differences. It interleaves back-to-back sets with idle gaps and a reset mid-stream, so that a misaligned valid chain, a wrong stage count or stale in-flight data shows up as a shifted or phantom out_valid.

// File: rtl/grav_pkg.sv
package grav_pkg;
  // Register stages between operand capture and result.
  localparam int unsigned GRAV_LATENCY = 4;

  function automatic int unsigned grav_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/grav_s1.sv
// Stage 1: constant times first mass, and both coordinate differences, side by side.
module grav_s1 #(
  parameter int CW = 12,
  parameter int MW = 12,
  parameter int KW = 8,
  parameter logic [KW-1:0] K_VAL = '0,
  localparam int DW = CW + 1,
  localparam int PW = KW + MW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 v_in,
  input  logic [MW-1:0]        m1,
  input  logic [MW-1:0]        m2,
  input  logic [CW-1:0]        pa [2],
  input  logic [CW-1:0]        pb [2],
  output logic                 v_out,
  output logic [PW-1:0]        km1_q,
  output logic [MW-1:0]        m2_q,
  output logic signed [DW-1:0] d_q [2]
);
  logic [PW-1:0]        km1_d;
  logic signed [DW-1:0] d_d [2];

  always_comb begin
    km1_d = PW'(K_VAL) * PW'(m1);
  end

  for (genvar a = 0; a < 2; a++) begin : g_diff
    always_comb begin
      d_d[a] = {pa[a][CW-1], pa[a]} - {pb[a][CW-1], pb[a]};
    end

    always_ff @(posedge clk) begin
      if (v_in) d_q[a] <= d_d[a];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_out <= 1'b0;
    else        v_out <= v_in;
  end

  always_ff @(posedge clk) begin
    if (v_in) begin
      km1_q <= km1_d;
      m2_q  <= m2;
    end
  end
endmodule

// File: rtl/grav_s2.sv
// Stage 2: full numerator product and both squarings, side by side.
module grav_s2 #(
  parameter int DW = 13,
  parameter int MW = 12,
  parameter int PW = 20,
  localparam int NW  = PW + MW,
  localparam int SQW = 2 * DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 v_in,
  input  logic [PW-1:0]        km1,
  input  logic [MW-1:0]        m2,
  input  logic signed [DW-1:0] d [2],
  output logic                 v_out,
  output logic [NW-1:0]        num_q,
  output logic [SQW-1:0]       sq_q [2]
);
  logic [NW-1:0] num_d;

  always_comb begin
    num_d = NW'(km1) * NW'(m2);
  end

  for (genvar a = 0; a < 2; a++) begin : g_sq
    logic signed [SQW-1:0] prod;
    always_comb begin
      prod = d[a] * d[a];
    end

    always_ff @(posedge clk) begin
      if (v_in) sq_q[a] <= prod;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_out <= 1'b0;
    else        v_out <= v_in;
  end

  always_ff @(posedge clk) begin
    if (v_in) num_q <= num_d;
  end
endmodule

// File: rtl/grav_s3.sv
// Stage 3: denominator sum; numerator carried unchanged.
module grav_s3 #(
  parameter int SQW = 26,
  parameter int NW  = 32,
  localparam int DENW = SQW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            v_in,
  input  logic [NW-1:0]   num,
  input  logic [SQW-1:0]  sq [2],
  output logic            v_out,
  output logic [NW-1:0]   num_q,
  output logic [DENW-1:0] den_q
);
  logic [DENW-1:0] den_d;

  always_comb begin
    den_d = DENW'(sq[0]) + DENW'(sq[1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_out <= 1'b0;
    else        v_out <= v_in;
  end

  always_ff @(posedge clk) begin
    if (v_in) begin
      num_q <= num;
      den_q <= den_d;
    end
  end
endmodule

// File: rtl/grav_s4.sv
// Stage 4: single-cycle divide with zero-distance guard.
module grav_s4 #(
  parameter int NW   = 32,
  parameter int DENW = 27,
  localparam int OPW = grav_pkg::grav_max(NW, DENW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            v_in,
  input  logic [NW-1:0]   num,
  input  logic [DENW-1:0] den,
  output logic            v_out,
  output logic [NW-1:0]   q_out,
  output logic            z_out
);
  logic [OPW-1:0] quo;
  logic [NW-1:0]  q_d;
  logic           z_d;
  logic [NW-1:0]  q_q;
  logic           z_q;
  logic           v_q;

  always_comb begin
    z_d = (den == '0);
    quo = z_d ? '0 : (OPW'(num) / OPW'(den));
    q_d = z_d ? '1 : quo[NW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= v_in;
  end

  always_ff @(posedge clk) begin
    if (v_in) begin
      q_q <= q_d;
      z_q <= z_d;
    end
  end

  assign v_out = v_q;
  assign q_out = q_q;
  assign z_out = z_q & v_q;
endmodule

// File: rtl/grav_pipe.sv
module grav_pipe #(
  parameter int CW = 12,
  parameter int MW = 12,
  parameter int KW = 8,
  parameter logic [KW-1:0] GRAV_K = 8'd5,
  localparam int DW   = CW + 1,
  localparam int PW   = KW + MW,
  localparam int SQW  = 2 * DW,
  localparam int DENW = SQW + 1,
  localparam int QW   = KW + 2 * MW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [MW-1:0] m1,
  input  logic [MW-1:0] m2,
  input  logic [CW-1:0] x1,
  input  logic [CW-1:0] y1,
  input  logic [CW-1:0] x2,
  input  logic [CW-1:0] y2,
  output logic          out_valid,
  output logic [QW-1:0] out_force,
  output logic          out_div0
);
  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta, rst_n_sync;
  logic [1:0] rst_chain_d;

  always_comb begin
    rst_chain_d = {rst_meta, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_n_sync, rst_meta} <= 2'b00;
    else        {rst_n_sync, rst_meta} <= rst_chain_d;
  end

  logic [CW-1:0] pa [2];
  logic [CW-1:0] pb [2];
  assign pa[0] = x1;
  assign pa[1] = y1;
  assign pb[0] = x2;
  assign pb[1] = y2;

  logic                 v1, v2, v3;
  logic [PW-1:0]        km1_1;
  logic [MW-1:0]        m2_1;
  logic signed [DW-1:0] d_1 [2];
  logic [QW-1:0]        num_2, num_3;
  logic [SQW-1:0]       sq_2 [2];
  logic [DENW-1:0]      den_3;

  grav_s1 #(.CW(CW), .MW(MW), .KW(KW), .K_VAL(GRAV_K)) u_s1 (
    .clk(clk), .rst_n(rst_n_sync), .v_in(in_valid),
    .m1(m1), .m2(m2), .pa(pa), .pb(pb),
    .v_out(v1), .km1_q(km1_1), .m2_q(m2_1), .d_q(d_1)
  );

  grav_s2 #(.DW(DW), .MW(MW), .PW(PW)) u_s2 (
    .clk(clk), .rst_n(rst_n_sync), .v_in(v1),
    .km1(km1_1), .m2(m2_1), .d(d_1),
    .v_out(v2), .num_q(num_2), .sq_q(sq_2)
  );

  grav_s3 #(.SQW(SQW), .NW(QW)) u_s3 (
    .clk(clk), .rst_n(rst_n_sync), .v_in(v2),
    .num(num_2), .sq(sq_2),
    .v_out(v3), .num_q(num_3), .den_q(den_3)
  );

  grav_s4 #(.NW(QW), .DENW(DENW)) u_s4 (
    .clk(clk), .rst_n(rst_n_sync), .v_in(v3),
    .num(num_3), .den(den_3),
    .v_out(out_valid), .q_out(out_force), .z_out(out_div0)
  );
endmodule

// File: rtl/grav_pipe_chk.sv
module grav_pipe_chk #(
  parameter int QW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          out_valid,
  input logic          out_div0,
  input logic [QW-1:0] out_force
);
  // Edges seen since the internal reset release, saturating at the latency.
  logic [2:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= 3'd0;
    else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
  end

  AST_LATENCY_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3'd4) |-> (out_valid == $past(in_valid, 4))); // R2

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 3'd4) |-> !out_valid); // R6

  AST_FLAG_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    out_div0 |-> out_valid); // R5

  AST_ZERO_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_div0) |-> (&out_force)); // R4
endmodule

bind grav_pipe grav_pipe_chk #(.QW(QW)) u_chk (
  .clk(clk), .rst_n(rst_n_sync), .in_valid(in_valid),
  .out_valid(out_valid), .out_div0(out_div0), .out_force(out_force)
);

// File: tb/grav_pipe_tb.sv
`timescale 1ns/1ps
module grav_pipe_tb;
  localparam int CW = 12;
  localparam int MW = 12;
  localparam int KW = 8;
  localparam int QW = KW + 2 * MW;

  typedef struct packed {
    logic [MW-1:0] m1;
    logic [MW-1:0] m2;
    logic [CW-1:0] x1;
    logic [CW-1:0] y1;
    logic [CW-1:0] x2;
    logic [CW-1:0] y2;
    logic [QW-1:0] f;
    logic          z;
  } vec_t;

  localparam int NV = 10;
  // GRAV_K = 5
  localparam vec_t VECS [NV] = '{
    '{12'd3,    12'd4,    12'd0,     12'd0,     12'd1,    12'd0,    32'd60,       1'b0}, // R1
    '{12'd10,   12'd10,   12'd3,     12'd4,     12'd0,    12'd0,    32'd20,       1'b0}, // R1
    '{12'd7,    12'd9,    -12'sd2,   -12'sd3,   12'd1,    12'd1,    32'd12,       1'b0}, // R8
    '{12'd1,    12'd1,    12'd5,     12'd5,     12'd5,    12'd5,    32'hFFFFFFFF, 1'b1}, // R4
    '{12'd7,    12'd9,    12'd1,     12'd1,     -12'sd2,  -12'sd3,  32'd12,       1'b0}, // R8 swapped
    '{12'd4095, 12'd4095, 12'd0,     12'd0,     12'd0,    12'd1,    32'd83845125, 1'b0}, // R7
    '{12'd4095, 12'd4095, -12'sd2048,-12'sd2048,12'd2047, 12'd2047, 32'd2,        1'b0}, // R7
    '{12'd0,    12'd9,    12'd1,     12'd1,     12'd0,    12'd0,    32'd0,        1'b0}, // R1
    '{12'd100,  12'd3,    12'd0,     12'd0,     12'd2,    12'd2,    32'd187,      1'b0}, // R1
    '{12'd255,  12'd255,  12'd10,    12'd0,     12'd0,    12'd7,    32'd2182,     1'b0}  // R1
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [MW-1:0] m1, m2;
  logic [CW-1:0] x1, y1, x2, y2;
  logic          out_valid;
  logic [QW-1:0] out_force;
  logic          out_div0;

  int checks = 0;
  int fails  = 0;

  logic pv [4];
  vec_t pe [4];

  always #2.5 clk = ~clk;

  grav_pipe u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .m1(m1), .m2(m2), .x1(x1), .y1(y1), .x2(x2), .y2(y2),
    .out_valid(out_valid), .out_force(out_force), .out_div0(out_div0)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic clear_pipe();
    for (int i = 0; i < 4; i++) pv[i] = 1'b0;
  endtask

  // One cycle: compare outputs with what was driven four cycles ago, then drive.
  task automatic step(input bit v, input vec_t e);
    @(negedge clk);
    check(out_valid === pv[3], "R2/R3/R9 out_valid", 64'(out_valid), 64'(pv[3]));
    if (pv[3]) begin
      check(out_force === pe[3].f, "R1/R4/R7/R8 out_force", 64'(out_force), 64'(pe[3].f));
      check(out_div0 === pe[3].z, "R4 out_div0", 64'(out_div0), 64'(pe[3].z));
    end else begin
      check(out_div0 === 1'b0, "R5 out_div0 idle", 64'(out_div0), 64'd0);
    end
    for (int i = 3; i > 0; i--) begin
      pv[i] = pv[i-1];
      pe[i] = pe[i-1];
    end
    pv[0] = v;
    pe[0] = e;
    in_valid = v;
    m1 = e.m1; m2 = e.m2;
    x1 = e.x1; y1 = e.y1; x2 = e.x2; y2 = e.y2;
  endtask

  initial begin
    vec_t idle;
    idle = '0;
    clear_pipe();
    rst_n = 1'b0;
    in_valid = 1'b1;
    m1 = '0; m2 = '0; x1 = '0; y1 = '0; x2 = '0; y2 = '0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R6 valid in reset", 64'(out_valid), 64'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    repeat (4) step(1'b0, idle);

    // Back-to-back stream
    for (int i = 0; i < NV; i++) step(1'b1, VECS[i]);
    repeat (4) step(1'b0, idle);

    // Stream with gaps
    for (int i = NV - 1; i >= 0; i--) begin
      step(1'b1, VECS[i]);
      if (i % 3 == 0) repeat (2) step(1'b0, idle);
      else            step(1'b0, idle);
    end
    repeat (4) step(1'b0, idle);

    // Reset with sets in flight
    step(1'b1, VECS[0]);
    step(1'b1, VECS[1]);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(out_valid === 1'b0, "R6 flush on reset", 64'(out_valid), 64'd0);
    clear_pipe();
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    check(out_valid === 1'b0, "R6 held in reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    repeat (6) step(1'b0, idle);
    step(1'b1, VECS[3]);
    repeat (5) step(1'b0, idle);

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule